// File: doc/BRIEF.md
# Condition Code Unit

This unit turns an operation selector and up to three 64-bit operands into a 2-bit condition code. The operands are a source, a destination and a result. It serves an execution pipeline that holds the operands of the last flag-setting operation and works out the code only when a later instruction needs it. It handles compares, signed and unsigned add and subtract, absolute value, negative absolute value, complement and nonzero tests at 32 and 64 bits. It also handles test-under-mask at two widths and insert-under-mask. The 32-bit forms look only at bits 31:0 of each operand.

A request is a one-cycle `valid_i` strobe. One clock edge later the new code is held on `cc_o` and `cc_vld_o` pulses for one cycle. A selector outside the supported set pulses `err_o` instead and leaves the held code as it was. A separate combinational path packs the held code and a 4-bit program mask into a copy of a general register. This serves an instruction that reads the code into a register.

Top module: `cc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `cc_o` becomes 0 and both `cc_vld_o` and `err_o` become 0.
- R2: A `valid_i` strobe with a supported selector loads the new code into `cc_o` and raises `cc_vld_o` for exactly the following cycle. Without a strobe, `cc_o` keeps its value whatever the other inputs do.
- R3: Compares use selector 0 (signed 32), 1 (signed 64), 2 (unsigned 32) and 3 (unsigned 64). The code is 0 when `src_i` equals `dst_i`, 1 when `src_i` is lower and 2 when it is higher, and never 3.
- R4: Signed add uses selectors 4 (32-bit) and 5 (64-bit); signed subtract uses 6 and 7. The code is 3 on overflow. For add, overflow means both operands are strictly positive and the result is negative, or both are negative and the result is strictly positive. For subtract, it means src is positive, dst is negative and the result is negative, or src is negative, dst is positive and the result is positive. Otherwise the code is 0 for a zero result, 1 for a negative result and 2 for a positive one.
- R5: Unsigned add uses selectors 8 (32-bit) and 9 (64-bit). A carry is present when the result is smaller than either operand. The code is 2×carry plus 1 if the result is nonzero. Unsigned subtract uses selectors 10 (32-bit) and 11 (64-bit). Its code is 2 for a zero result, 1 when dst exceeds src and 3 otherwise.
- R6: These single-operand codes look at `dst_i`. Absolute value (12/13) gives 3 for the most negative value, 2 for other nonzero values and 0 for zero. Negative absolute value (14/15) and the nonzero test (18/19) give 1 for nonzero and 0 for zero. Complement (16/17) gives 3 for the most negative value, 1 for negative, 2 for positive and 0 for zero.
- R7: Test-under-mask (20 for the short form, 21 for the long form) ANDs `src_i[15:0]` with the mask `dst_i[15:0]`. The code is 0 when the AND or the mask is zero, and 3 when the AND equals the mask. In every other case the short form gives 1.
- R8: In the mixed case of the long form, the most significant set bit of the mask picks a bit of `src_i`. The code is 2 if that bit is 1 and 1 if it is 0.
- R9: Insert-under-mask (22) uses `src_i[3:0]` to select bytes of `dst_i[31:0]`; bit k selects bits 8k+7:8k. The code is 0 when no byte is selected or all selected bytes are zero. Otherwise it is 1 when the top bit of the most significant selected byte is set, and 2 when it is clear.
- R10: `gpr_o` equals `gpr_i` in bits 63:32 and 23:0. Bits 31:30 are zero, bits 29:28 carry `cc_o` and bits 27:24 carry `pmask_i`.
- R11: A strobe with a selector from 23 to 31 raises `err_o` for the following cycle, leaves `cc_vld_o` low and leaves `cc_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 5 | Operation selector |
| src_i | input | 64 | Source operand |
| dst_i | input | 64 | Destination operand |
| res_i | input | 64 | Result of the add or subtract |
| gpr_i | input | 64 | Register image to pack the code into |
| pmask_i | input | 4 | Program mask bits |
| cc_o | output | 2 | Held condition code |
| cc_vld_o | output | 1 | One-cycle pulse after a supported request |
| err_o | output | 1 | One-cycle pulse after an unsupported request |
| gpr_o | output | 64 | Packed register image |

## Verification
Some properties are checked on every cycle. The held code stays put when nothing valid arrives or an error pulses. A valid pulse and an error pulse never coincide, and a valid pulse always follows a strobe. Compares never yield 3, and negative absolute value and the nonzero test never yield 2 or 3. Other behaviour only the bench's sweeps over corner operands can show. This covers which code each selector produces, the overflow and carry cases at both widths, the most-negative handling, the choice made by the leftmost mask bit, byte selection for insert-under-mask and the packed register layout.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int DATA_W    = 64;
    localparam int HALF_W    = DATA_W / 2;
    localparam int CC_W      = 2;
    localparam int OP_W      = 5;
    localparam int TM_W      = 16;
    localparam int ICM_LANES = 4;
    localparam int PM_W      = 4;
    localparam int PM_POS    = 24;
    localparam int CC_POS    = PM_POS + PM_W;
    localparam int LANES     = 2;

    typedef enum logic [OP_W-1:0] {
        OP_CMPS32 = 5'd0,  OP_CMPS64 = 5'd1,  OP_CMPU32 = 5'd2,  OP_CMPU64 = 5'd3,
        OP_ADDS32 = 5'd4,  OP_ADDS64 = 5'd5,  OP_SUBS32 = 5'd6,  OP_SUBS64 = 5'd7,
        OP_ADDU32 = 5'd8,  OP_ADDU64 = 5'd9,  OP_SUBU32 = 5'd10, OP_SUBU64 = 5'd11,
        OP_ABS32  = 5'd12, OP_ABS64  = 5'd13, OP_NABS32 = 5'd14, OP_NABS64 = 5'd15,
        OP_CPL32  = 5'd16, OP_CPL64  = 5'd17, OP_NZ32   = 5'd18, OP_NZ64   = 5'd19,
        OP_TMS    = 5'd20, OP_TML    = 5'd21, OP_ICM    = 5'd22
    } op_e;

    typedef logic [CC_W-1:0] cc_t;

    typedef struct packed {
        cc_t cmp_s;
        cc_t cmp_u;
        cc_t add_s;
        cc_t sub_s;
        cc_t add_u;
        cc_t sub_u;
        cc_t abs_v;
        cc_t nabs_v;
        cc_t cpl_v;
        cc_t nz_v;
    } lane_cc_t;

    // Sign class of a result: 0 zero, 1 negative, 2 positive.
    function automatic cc_t sign_class(input logic is_zero, input logic is_neg);
        if (is_zero)     return 2'd0;
        else if (is_neg) return 2'd1;
        else             return 2'd2;
    endfunction
endpackage

// File: rtl/cc_lane.sv
module cc_lane
    import cc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] r_i,
    output lane_cc_t     cc_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic a_neg, b_neg, r_neg, a_pos, b_pos, r_pos;
    logic r_zero, b_zero, b_min, add_ovf, sub_ovf, carry;

    always_comb begin
        a_neg  = a_i[W-1];
        b_neg  = b_i[W-1];
        r_neg  = r_i[W-1];
        a_pos  = !a_neg && (a_i != '0);
        b_pos  = !b_neg && (b_i != '0);
        r_pos  = !r_neg && (r_i != '0);
        r_zero = (r_i == '0);
        b_zero = (b_i == '0);
        b_min  = (b_i == MOST_NEG);

        add_ovf = (a_pos && b_pos && r_neg) || (a_neg && b_neg && r_pos);
        sub_ovf = (a_pos && b_neg && r_neg) || (a_neg && b_pos && r_pos);
        carry   = (r_i < a_i) || (r_i < b_i);

        if (a_i == b_i)                      cc_o.cmp_s = 2'd0;
        else if ($signed(a_i) < $signed(b_i)) cc_o.cmp_s = 2'd1;
        else                                 cc_o.cmp_s = 2'd2;

        if (a_i == b_i)     cc_o.cmp_u = 2'd0;
        else if (a_i < b_i) cc_o.cmp_u = 2'd1;
        else                cc_o.cmp_u = 2'd2;

        cc_o.add_s = add_ovf ? 2'd3 : sign_class(r_zero, r_neg);
        cc_o.sub_s = sub_ovf ? 2'd3 : sign_class(r_zero, r_neg);
        cc_o.add_u = {carry, !r_zero};

        if (r_zero)         cc_o.sub_u = 2'd2;
        else if (b_i > a_i) cc_o.sub_u = 2'd1;
        else                cc_o.sub_u = 2'd3;

        cc_o.abs_v  = b_min ? 2'd3 : (b_zero ? 2'd0 : 2'd2);
        cc_o.nabs_v = {1'b0, !b_zero};
        cc_o.cpl_v  = b_min ? 2'd3 : sign_class(b_zero, b_neg);
        cc_o.nz_v   = {1'b0, !b_zero};
    end
endmodule

// File: rtl/cc_mask.sv
module cc_mask
    import cc_pkg::*;
#(
    parameter int MW    = TM_W,
    parameter int BYTES = ICM_LANES
) (
    input  logic [MW-1:0]      tm_val_i,
    input  logic [MW-1:0]      tm_mask_i,
    input  logic [BYTES-1:0]   icm_sel_i,
    input  logic [8*BYTES-1:0] icm_val_i,
    output cc_t                tm_short_o,
    output cc_t                tm_long_o,
    output cc_t                icm_o
);
    localparam int PW = $clog2(MW);

    logic [MW-1:0] hit;
    logic [PW-1:0] lead;
    logic          any_set, top_bit;

    always_comb begin
        hit  = tm_val_i & tm_mask_i;
        lead = '0;
        for (int i = 0; i < MW; i++) begin
            if (tm_mask_i[i]) lead = PW'(i);
        end
        if (hit == '0 || tm_mask_i == '0) begin
            tm_short_o = 2'd0;
            tm_long_o  = 2'd0;
        end else if (hit == tm_mask_i) begin
            tm_short_o = 2'd3;
            tm_long_o  = 2'd3;
        end else begin
            tm_short_o = 2'd1;
            tm_long_o  = tm_val_i[lead] ? 2'd2 : 2'd1;
        end

        any_set = 1'b0;
        top_bit = 1'b0;
        for (int l = 0; l < BYTES; l++) begin
            if (icm_sel_i[l]) begin
                any_set = any_set | (|icm_val_i[8*l +: 8]);
                top_bit = icm_val_i[8*l + 7];
            end
        end
        icm_o = !any_set ? 2'd0 : (top_bit ? 2'd1 : 2'd2);
    end
endmodule

// File: rtl/cc_ipm.sv
module cc_ipm
    import cc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0]   gpr_i,
    input  cc_t             cc_i,
    input  logic [PM_W-1:0] pm_i,
    output logic [DW-1:0]   gpr_o
);
    always_comb begin
        gpr_o                      = gpr_i;
        gpr_o[HALF_W-1:PM_POS]     = '0;
        gpr_o[PM_POS +: PM_W]      = pm_i;
        gpr_o[CC_POS +: CC_W]      = cc_i;
    end
endmodule

// File: rtl/cc_unit.sv
module cc_unit
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] gpr_i,
    input  logic [PM_W-1:0]   pmask_i,
    output logic [CC_W-1:0]   cc_o,
    output logic              cc_vld_o,
    output logic              err_o,
    output logic [DATA_W-1:0] gpr_o
);
    lane_cc_t lane_cc [LANES];
    cc_t      tm_short, tm_long, icm_cc, next_cc;
    logic     legal;
    lane_cc_t sel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? HALF_W : DATA_W;
        cc_lane #(.W(LW)) lane_i (
            .a_i (src_i[LW-1:0]),
            .b_i (dst_i[LW-1:0]),
            .r_i (res_i[LW-1:0]),
            .cc_o(lane_cc[g])
        );
    end

    cc_mask #(.MW(TM_W), .BYTES(ICM_LANES)) mask_i (
        .tm_val_i  (src_i[TM_W-1:0]),
        .tm_mask_i (dst_i[TM_W-1:0]),
        .icm_sel_i (src_i[ICM_LANES-1:0]),
        .icm_val_i (dst_i[8*ICM_LANES-1:0]),
        .tm_short_o(tm_short),
        .tm_long_o (tm_long),
        .icm_o     (icm_cc)
    );

    cc_ipm #(.DW(DATA_W)) ipm_i (
        .gpr_i(gpr_i),
        .cc_i (cc_o),
        .pm_i (pmask_i),
        .gpr_o(gpr_o)
    );

    always_comb begin
        sel     = lane_cc[op_i[0]];
        legal   = 1'b1;
        next_cc = cc_o;
        case (op_i)
            OP_CMPS32, OP_CMPS64: next_cc = sel.cmp_s;
            OP_CMPU32, OP_CMPU64: next_cc = sel.cmp_u;
            OP_ADDS32, OP_ADDS64: next_cc = sel.add_s;
            OP_SUBS32, OP_SUBS64: next_cc = sel.sub_s;
            OP_ADDU32, OP_ADDU64: next_cc = sel.add_u;
            OP_SUBU32, OP_SUBU64: next_cc = sel.sub_u;
            OP_ABS32,  OP_ABS64:  next_cc = sel.abs_v;
            OP_NABS32, OP_NABS64: next_cc = sel.nabs_v;
            OP_CPL32,  OP_CPL64:  next_cc = sel.cpl_v;
            OP_NZ32,   OP_NZ64:   next_cc = sel.nz_v;
            OP_TMS:               next_cc = tm_short;
            OP_TML:               next_cc = tm_long;
            OP_ICM:               next_cc = icm_cc;
            default:              legal   = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_o     <= '0;
            cc_vld_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            cc_vld_o <= valid_i && legal;
            err_o    <= valid_i && !legal;
            if (valid_i && legal) cc_o <= next_cc;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cc_vld_o |-> cc_o == $past(cc_o)); // R2
    AST_VLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        cc_vld_o |-> $past(valid_i)); // R2
    AST_ERR_KEEPS_CC: assert property (@(posedge clk) disable iff (rst)
        err_o |-> cc_o == $past(cc_o)); // R11
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(cc_vld_o && err_o)); // R11
    AST_CMP_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (cc_vld_o && $past(op_i) <= OP_CMPU64) |-> cc_o != 2'd3); // R3
    AST_NABS_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cc_vld_o && ($past(op_i) == OP_NABS32 || $past(op_i) == OP_NABS64 ||
                      $past(op_i) == OP_NZ32   || $past(op_i) == OP_NZ64)) |-> !cc_o[1]); // R6
endmodule

// File: tb/cc_unit_tb_top.sv
`timescale 1ns/1ps
module cc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic [63:0] src_i = '0, dst_i = '0, res_i = '0, gpr_i = '0;
    logic [3:0]  pmask_i = '0;
    logic [1:0]  cc_o;
    logic        cc_vld_o, err_o;
    logic [63:0] gpr_o;

    int checks = 0;
    int fails  = 0;
    int model_cc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cc_unit dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .src_i(src_i), .dst_i(dst_i), .res_i(res_i), .gpr_i(gpr_i),
        .pmask_i(pmask_i), .cc_o(cc_o), .cc_vld_o(cc_vld_o), .err_o(err_o),
        .gpr_o(gpr_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        if (op <= 3)       return "R3";
        else if (op <= 7)  return "R4";
        else if (op <= 11) return "R5";
        else if (op <= 19) return "R6";
        else if (op == 20) return "R7";
        else if (op == 21) return "R7 R8";
        else if (op == 22) return "R9";
        else               return "R11";
    endfunction

    function automatic int exp_cc(input int op, input logic [63:0] s, d, r);
        bit lane64 = (op % 2) == 1;
        longint a  = lane64 ? longint'(s) : longint'(int'(s[31:0]));
        longint b  = lane64 ? longint'(d) : longint'(int'(d[31:0]));
        longint ar = lane64 ? longint'(r) : longint'(int'(r[31:0]));
        logic [63:0] ua = lane64 ? s : {32'd0, s[31:0]};
        logic [63:0] ub = lane64 ? d : {32'd0, d[31:0]};
        logic [63:0] ur = lane64 ? r : {32'd0, r[31:0]};
        bit is_min = lane64 ? (d == 64'h8000_0000_0000_0000) : (d[31:0] == 32'h8000_0000);
        int code;
        if (op == 20 || op == 21) begin
            logic [15:0] m = d[15:0];
            logic [15:0] v = s[15:0];
            logic [15:0] hit = v & m;
            if (hit == 0 || m == 0) return 0;
            if (hit == m) return 3;
            if (op == 20) return 1;
            while (!m[15]) begin m = m << 1; v = v << 1; end
            return v[15] ? 2 : 1;
        end
        if (op == 22) begin
            logic [31:0] t = '0;
            int n = 0;
            for (int k = 3; k >= 0; k--) begin
                if (s[k]) begin t = (t << 8) | {24'd0, d[8*k +: 8]}; n++; end
            end
            if (n == 0 || t == 0) return 0;
            return t[8*n-1] ? 1 : 2;
        end
        if (op > 22) return -1;
        case (op / 2)
            0: code = (a == b) ? 0 : (a < b) ? 1 : 2;
            1: code = (ua == ub) ? 0 : (ua < ub) ? 1 : 2;
            2: code = ((a > 0 && b > 0 && ar < 0) || (a < 0 && b < 0 && ar > 0)) ? 3 :
                      (ar == 0) ? 0 : (ar < 0) ? 1 : 2;
            3: code = ((a > 0 && b < 0 && ar < 0) || (a < 0 && b > 0 && ar > 0)) ? 3 :
                      (ar == 0) ? 0 : (ar < 0) ? 1 : 2;
            4: code = ((ur < ua || ur < ub) ? 2 : 0) + ((ur != 0) ? 1 : 0);
            5: code = (ur == 0) ? 2 : (ub > ua) ? 1 : 3;
            6: code = is_min ? 3 : (b != 0) ? 2 : 0;
            7: code = (b != 0) ? 1 : 0;
            8: code = is_min ? 3 : (b < 0) ? 1 : (b > 0) ? 2 : 0;
            default: code = (ub != 0) ? 1 : 0;
        endcase
        return code;
    endfunction

    task automatic run(input int op, input logic [63:0] s, d, r);
        int e;
        @(negedge clk);
        valid_i = 1'b1; op_i = 5'(op); src_i = s; dst_i = d; res_i = r;
        @(negedge clk);
        valid_i = 1'b0;
        e = exp_cc(op, s, d, r);
        if (e < 0) begin
            check(err_o && !cc_vld_o && cc_o == 2'(model_cc), "R11",
                  $sformatf("op %0d err/vld/cc", op),
                  {err_o, cc_vld_o, cc_o}, {1'b1, 1'b0, 2'(model_cc)});
        end else begin
            check(cc_vld_o && !err_o && cc_o == 2'(e), req_of(op),
                  $sformatf("op %0d src %h dst %h res %h", op, s, d, r),
                  {cc_vld_o, cc_o}, {1'b1, 2'(e)});
            model_cc = e;
        end
    endtask

    task automatic check_ipm(input logic [63:0] g, input logic [3:0] pm);
        logic [63:0] e;
        gpr_i = g; pmask_i = pm;
        #1;
        e = (g & 64'hFFFF_FFFF_00FF_FFFF) | (64'(model_cc) << 28) | (64'(pm) << 24);
        check(gpr_o == e, "R10", "packed register", gpr_o, e);
    endtask

    logic [63:0] vals [8];

    initial begin
        vals[0] = 64'h0; vals[1] = 64'h1; vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[3] = 64'h8000_0000_0000_0000; vals[4] = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[5] = 64'h0000_0000_8000_0000; vals[6] = 64'h0000_0000_7FFF_FFFF;
        vals[7] = 64'h1234_5678_9ABC_DEF0;

        repeat (4) @(negedge clk);
        check(cc_o == 0 && !cc_vld_o && !err_o, "R1", "reset state",
              {cc_o, cc_vld_o, err_o}, 0);
        rst = 1'b0;

        for (int op = 0; op < 20; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [63:0] s = vals[i], d = vals[j], r;
                    int grp = op / 2;
                    if (grp == 2 || grp == 4)      r = s + d;
                    else if (grp == 3 || grp == 5) r = s - d;
                    else                           r = vals[(i + j) % 8];
                    run(op, s, d, r);
                end
            end
            check_ipm(64'hDEAD_BEEF_CAFE_F00D ^ 64'(op), 4'(op));
        end

        for (int mi = 0; mi < 128; mi++) begin
            for (int vj = 0; vj < 8; vj++) begin
                logic [15:0] m = 16'(mi * 517);
                logic [15:0] v = (vj == 0) ? 16'hFFFF : 16'((vj * 4369) ^ (mi * 77));
                run(20, {48'hA5A5_5A5A_0F0F, v}, {48'h3C3C_C3C3_F0F0, m}, 64'h0);
                run(21, {48'hA5A5_5A5A_0F0F, v}, {48'h3C3C_C3C3_F0F0, m}, 64'h0);
            end
        end
        // R8 leftmost-mask-bit cases written out
        run(21, 64'h0000_0000_0000_0040, 64'h0000_0000_0000_00C1, 64'h0);
        run(21, 64'h0000_0000_0000_0081, 64'h0000_0000_0000_00C1, 64'h0);

        for (int k = 0; k < 16; k++) begin
            logic [31:0] iv [8];
            iv[0] = 32'h0; iv[1] = 32'h8000_0000; iv[2] = 32'h0080_0000;
            iv[3] = 32'h0000_8000; iv[4] = 32'h0000_0080; iv[5] = 32'h7F7F_7F7F;
            iv[6] = 32'h0100_0000; iv[7] = 32'h1234_5678;
            for (int j = 0; j < 8; j++) run(22, {60'h0, 4'(k)}, {32'hFFFF_FFFF, iv[j]}, 64'h0);
            check_ipm(64'h0123_4567_89AB_CDEF, 4'(15 - k));
        end

        // R11 unsupported selectors after a known code
        for (int op = 23; op < 32; op++) begin
            run(0, 64'h5, 64'h9, 64'h0);
            run(op, 64'h9, 64'h5, 64'h0);
        end

        // R2 no strobe: inputs move, code holds
        run(5, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000);
        @(negedge clk);
        op_i = 5'd0; src_i = 64'h1; dst_i = 64'h2; res_i = 64'h0;
        repeat (3) @(negedge clk);
        check(cc_o == 2'(model_cc) && !cc_vld_o && !err_o, "R2", "hold without strobe",
              {cc_vld_o, cc_o}, model_cc);

        // R1 reset mid-run clears the code
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(cc_o == 0 && !cc_vld_o && !err_o, "R1", "reset after activity",
              {cc_o, cc_vld_o, err_o}, 0);
        rst = 1'b0;
        model_cc = 0;
        check_ipm(64'hFFFF_FFFF_FFFF_FFFF, 4'hA);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule